// File: doc/BRIEF.md
# Peripheral Resource and Interrupt Router

This block sits behind the configuration register file of a multifunction I/O controller. From the raw register bytes it works out where each integrated peripheral lives on the I/O map, whether it is switched on, and which interrupt line it drives. The peripherals are two serial ports, one parallel port, a real-time clock and a game port. The peripheral decoders downstream take their settings from this block's outputs.

The registered outputs change only when the apply strobe is pulsed, which normally happens as the configuration sequence is left. While the host is inside configuration mode, the serial, parallel and game port enables are forced low. The clock's base address and interrupt stay as they were. Every base address is the programmed byte shifted left by two.

Interrupt steering is organised by line, not by source. Four 2-bit selector fields each hand one physical line to at most one source. The fields are walked in a fixed order, and a later field that names the same source replaces the earlier assignment. A source that ends up with no line reports the no-interrupt code. The clock also answers at a fixed port alongside its programmable base.

Top module: `pirq_router`

## Requirements
- R1: After reset all four enables are low. The bases are rtc 0x2C0, uart1 0x3F8, uart2 0x2F8, parallel 0x278 and game 0x200. The IRQs are rtc 0xF, uart1 4, uart2 3 and parallel 5, which is the decode of selector byte 0xEC.
- R2: On an apply strobe, each 10-bit base output loads its 8-bit configuration input shifted left by two. The new value is visible after the next rising edge.
- R3: On an apply strobe, the enable input loads the enables as follows: bit 0 to the game port, bit 1 to uart1, bit 2 to uart2 and bit 3 to the parallel port.
- R4: Selector bits [7:6] control line 3. The value 01 gives it to the rtc, 10 to uart1 and 11 to uart2.
- R5: Selector bits [5:4] control line 4. The value 01 gives it to the rtc, 10 to uart1 and 11 to uart2.
- R6: Selector bits [3:2] control line 5. The value 01 gives it to the rtc, 10 to uart1 and 11 to the parallel port.
- R7: Selector bits [1:0] control line 7. The value 01 gives it to the rtc, 10 to uart2 and 11 to the parallel port.
- R8: A field value of 00 assigns nothing. A source with no assigned line reports 0xF. No line number appears on two sources at once.
- R9: Fields are applied in the order line 3, 4, 5, 7. When two fields name the same source, the later one sets that source's IRQ.
- R10: In any cycle with configuration mode high and no apply strobe, the uart1, uart2, parallel and game enables go low at the next edge. They stay low until the next apply. The rtc base and every IRQ are not touched.
- R11: Without an apply strobe, changes on the configuration inputs have no effect on any base or IRQ output.
- R12: The rtc fixed-port output always reads 0x070.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 1 | Configuration mode is active |
| apply_stb | input | 1 | One-cycle strobe that latches all settings |
| cfg_enable | input | 4 | Enable bits: game, uart1, uart2, parallel (bit 0 upward) |
| cfg_rtc_base | input | 8 | RTC base byte |
| cfg_uart1_base | input | 8 | UART1 base byte |
| cfg_uart2_base | input | 8 | UART2 base byte |
| cfg_par_base | input | 8 | Parallel port base byte |
| cfg_game_base | input | 8 | Game port base byte |
| cfg_irq_sel | input | 8 | Four 2-bit interrupt line selectors |
| game_en | output | 1 | Game port enable |
| uart1_en | output | 1 | UART1 enable |
| uart2_en | output | 1 | UART2 enable |
| par_en | output | 1 | Parallel port enable |
| rtc_base | output | 10 | RTC programmable base |
| rtc_fixed_base | output | 10 | RTC fixed decode port |
| uart1_base | output | 10 | UART1 base |
| uart2_base | output | 10 | UART2 base |
| par_base | output | 10 | Parallel port base |
| game_base | output | 10 | Game port base |
| rtc_irq | output | 4 | RTC interrupt line, 0xF for none |
| uart1_irq | output | 4 | UART1 interrupt line, 0xF for none |
| uart2_irq | output | 4 | UART2 interrupt line, 0xF for none |
| par_irq | output | 4 | Parallel port interrupt line, 0xF for none |

## Verification
Some properties are checked on every cycle:
- base and IRQ outputs never move without an apply;
- an apply loads each base as its input times four and loads the enable bits in their stated positions;
- configuration mode without an apply clears the four gated enables;
- every IRQ is one of the four line numbers or 0xF, and no line number is shared by two sources.

Other properties can only be shown by the bench's scenarios:
- the exact source that each selector code maps to;
- the override order when several fields name one source;
- the reset decode of 0xEC;
- enables staying low after configuration mode drops without an apply.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

   // interrupt sources that can receive a line
   typedef enum logic [1:0] {
      SRC_RTC   = 2'd0,
      SRC_UART1 = 2'd1,
      SRC_UART2 = 2'd2,
      SRC_PAR   = 2'd3
   } irq_src_e;

   localparam int NUM_SRC   = 4;
   localparam int NUM_LINES = 4;
   localparam int SEL_W     = 2 * NUM_LINES;

   // peripheral order inside the base-address vector
   localparam int B_RTC   = 0;
   localparam int B_UART1 = 1;
   localparam int B_UART2 = 2;
   localparam int B_PAR   = 3;
   localparam int B_GAME  = 4;
   localparam int NUM_BASE = 5;

   typedef struct packed {
      logic     hit;
      irq_src_e src;
   } route_t;

   // Field index 0 = first-evaluated line (3), 3 = last (7).
   // Code 01 always picks the clock; 10/11 differ per field.
   function automatic route_t route_of(input int unsigned fld, input logic [1:0] code);
      route_t r;
      r.hit = (code != 2'b00);
      r.src = SRC_RTC;
      case (code)
         2'b01: r.src = SRC_RTC;
         2'b10: r.src = (fld == 3) ? SRC_UART2 : SRC_UART1;
         2'b11: r.src = (fld < 2)  ? SRC_UART2 : SRC_PAR;
         default: r.src = SRC_RTC;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/pirq_base_scale.sv
module pirq_base_scale #(
   parameter int N      = 5,
   parameter int REG_W  = 8,
   parameter int SHIFT  = 2,
   localparam int ADDR_W = REG_W + SHIFT
) (
   input  logic [N-1:0][REG_W-1:0]  base_raw,
   output logic [N-1:0][ADDR_W-1:0] base_addr
);

   if (N < 1) begin : g_bad_n
      $error("pirq_base_scale: N must be at least 1");
   end
   if (SHIFT < 0) begin : g_bad_shift
      $error("pirq_base_scale: SHIFT must not be negative");
   end

   for (genvar i = 0; i < N; i++) begin : g_scale
      if (SHIFT == 0) begin : g_noshift
         assign base_addr[i] = base_raw[i];
      end else begin : g_shift
         assign base_addr[i] = {base_raw[i], {SHIFT{1'b0}}};
      end
   end

endmodule

// File: rtl/pirq_irq_steer.sv
module pirq_irq_steer
   import pirq_pkg::*;
#(
   parameter int IRQ_W = 4,
   parameter logic [IRQ_W-1:0] NO_IRQ = '1,
   // line number per field, index 0 evaluated first
   parameter logic [NUM_LINES-1:0][7:0] LINE_NUM = {8'd7, 8'd5, 8'd4, 8'd3},
   // 0: later field overrides earlier, 1: first field wins
   parameter bit FIRST_WINS = 1'b0
) (
   input  logic [SEL_W-1:0]               sel,
   output logic [NUM_SRC-1:0][IRQ_W-1:0]  src_irq
);

   for (genvar k = 0; k < NUM_LINES; k++) begin : g_line_chk
      if (int'(LINE_NUM[k]) >= (1 << IRQ_W) || LINE_NUM[k][IRQ_W-1:0] == NO_IRQ) begin : g_bad_line
         $error("pirq_irq_steer: line number does not fit or collides with NO_IRQ");
      end
   end

   always_comb begin
      route_t r;
      int unsigned kk;
      for (int s = 0; s < NUM_SRC; s++) src_irq[s] = NO_IRQ;
      for (int k = 0; k < NUM_LINES; k++) begin
         kk = FIRST_WINS ? unsigned'(NUM_LINES - 1 - k) : unsigned'(k);
         // field kk lives in the top bits for kk = 0
         r = route_of(kk, sel[SEL_W-2-2*kk +: 2]);
         if (r.hit) src_irq[r.src] = LINE_NUM[kk][IRQ_W-1:0];
      end
   end

endmodule

// File: rtl/pirq_enable_gate.sv
module pirq_enable_gate #(
   parameter int NUM_EN = 4,
   parameter logic [NUM_EN-1:0] RST_VAL = '0,
   // bits cleared while configuration mode is held
   parameter logic [NUM_EN-1:0] GATE_MASK = '1,
   parameter bit CFG_GATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_mode,
   input  logic              apply_stb,
   input  logic [NUM_EN-1:0] en_in,
   output logic [NUM_EN-1:0] en_q
);

   if (NUM_EN < 1) begin : g_bad_n
      $error("pirq_enable_gate: NUM_EN must be at least 1");
   end

   if (CFG_GATE) begin : g_gated
      always_ff @(posedge clk) begin
         if (!rst_n)          en_q <= RST_VAL;
         else if (apply_stb)  en_q <= en_in;
         else if (cfg_mode)   en_q <= en_q & ~GATE_MASK;
      end
   end else begin : g_plain
      always_ff @(posedge clk) begin
         if (!rst_n)          en_q <= RST_VAL;
         else if (apply_stb)  en_q <= en_in;
      end
   end

endmodule

// File: rtl/pirq_router.sv
module pirq_router
   import pirq_pkg::*;
#(
   parameter int REG_W      = 8,
   parameter int ADDR_SHIFT = 2,
   parameter int IRQ_W      = 4,
   parameter logic [IRQ_W-1:0] NO_IRQ = '1,
   parameter logic [REG_W-1:0] DEF_RTC  = 8'hB0,
   parameter logic [REG_W-1:0] DEF_UART1 = 8'hFE,
   parameter logic [REG_W-1:0] DEF_UART2 = 8'hBE,
   parameter logic [REG_W-1:0] DEF_PAR  = 8'h9E,
   parameter logic [REG_W-1:0] DEF_GAME = 8'h80,
   parameter logic [7:0]       DEF_SEL  = 8'hEC,
   parameter logic [3:0]       DEF_EN   = 4'h0,
   parameter int RTC_FIXED_PORT = 'h070,
   parameter bit FIRST_WINS = 1'b0,
   localparam int ADDR_W = REG_W + ADDR_SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_mode,
   input  logic              apply_stb,
   input  logic [3:0]        cfg_enable,
   input  logic [REG_W-1:0]  cfg_rtc_base,
   input  logic [REG_W-1:0]  cfg_uart1_base,
   input  logic [REG_W-1:0]  cfg_uart2_base,
   input  logic [REG_W-1:0]  cfg_par_base,
   input  logic [REG_W-1:0]  cfg_game_base,
   input  logic [7:0]        cfg_irq_sel,
   output logic              game_en,
   output logic              uart1_en,
   output logic              uart2_en,
   output logic              par_en,
   output logic [ADDR_W-1:0] rtc_base,
   output logic [ADDR_W-1:0] rtc_fixed_base,
   output logic [ADDR_W-1:0] uart1_base,
   output logic [ADDR_W-1:0] uart2_base,
   output logic [ADDR_W-1:0] par_base,
   output logic [ADDR_W-1:0] game_base,
   output logic [IRQ_W-1:0]  rtc_irq,
   output logic [IRQ_W-1:0]  uart1_irq,
   output logic [IRQ_W-1:0]  uart2_irq,
   output logic [IRQ_W-1:0]  par_irq
);

   if (RTC_FIXED_PORT >= (1 << ADDR_W)) begin : g_bad_fixed
      $error("pirq_router: fixed clock port does not fit the address width");
   end
   if (IRQ_W < 3) begin : g_bad_irqw
      $error("pirq_router: IRQ_W too narrow for line 7");
   end

   // ---------------- base addresses ----------------
   logic [NUM_BASE-1:0][REG_W-1:0]  raw_now, raw_def;
   logic [NUM_BASE-1:0][ADDR_W-1:0] addr_now, addr_def;
   logic [NUM_BASE-1:0][ADDR_W-1:0] base_q;

   always_comb begin
      raw_now[B_RTC]   = cfg_rtc_base;
      raw_now[B_UART1] = cfg_uart1_base;
      raw_now[B_UART2] = cfg_uart2_base;
      raw_now[B_PAR]   = cfg_par_base;
      raw_now[B_GAME]  = cfg_game_base;
      raw_def[B_RTC]   = DEF_RTC;
      raw_def[B_UART1] = DEF_UART1;
      raw_def[B_UART2] = DEF_UART2;
      raw_def[B_PAR]   = DEF_PAR;
      raw_def[B_GAME]  = DEF_GAME;
   end

   pirq_base_scale #(.N(NUM_BASE), .REG_W(REG_W), .SHIFT(ADDR_SHIFT)) u_scale_now (
      .base_raw (raw_now),
      .base_addr(addr_now)
   );

   pirq_base_scale #(.N(NUM_BASE), .REG_W(REG_W), .SHIFT(ADDR_SHIFT)) u_scale_def (
      .base_raw (raw_def),
      .base_addr(addr_def)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)         base_q <= addr_def;
      else if (apply_stb) base_q <= addr_now;
   end

   assign rtc_base   = base_q[B_RTC];
   assign uart1_base = base_q[B_UART1];
   assign uart2_base = base_q[B_UART2];
   assign par_base   = base_q[B_PAR];
   assign game_base  = base_q[B_GAME];
   assign rtc_fixed_base = ADDR_W'(RTC_FIXED_PORT);

   // ---------------- interrupt steering ----------------
   logic [NUM_SRC-1:0][IRQ_W-1:0] irq_now, irq_def, irq_q;

   pirq_irq_steer #(.IRQ_W(IRQ_W), .NO_IRQ(NO_IRQ), .FIRST_WINS(FIRST_WINS)) u_steer_now (
      .sel    (cfg_irq_sel),
      .src_irq(irq_now)
   );

   pirq_irq_steer #(.IRQ_W(IRQ_W), .NO_IRQ(NO_IRQ), .FIRST_WINS(FIRST_WINS)) u_steer_def (
      .sel    (DEF_SEL),
      .src_irq(irq_def)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)         irq_q <= irq_def;
      else if (apply_stb) irq_q <= irq_now;
   end

   assign rtc_irq   = irq_q[SRC_RTC];
   assign uart1_irq = irq_q[SRC_UART1];
   assign uart2_irq = irq_q[SRC_UART2];
   assign par_irq   = irq_q[SRC_PAR];

   // ---------------- enables ----------------
   logic [3:0] en_q;

   pirq_enable_gate #(.NUM_EN(4), .RST_VAL(DEF_EN), .GATE_MASK(4'hF), .CFG_GATE(1'b1)) u_en (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_mode (cfg_mode),
      .apply_stb(apply_stb),
      .en_in    (cfg_enable),
      .en_q     (en_q)
   );

   assign game_en  = en_q[0];
   assign uart1_en = en_q[1];
   assign uart2_en = en_q[2];
   assign par_en   = en_q[3];

endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk #(
   parameter int REG_W      = 8,
   parameter int ADDR_SHIFT = 2,
   parameter int IRQ_W      = 4,
   parameter logic [IRQ_W-1:0] NO_IRQ = '1,
   localparam int ADDR_W = REG_W + ADDR_SHIFT
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_mode,
   input logic              apply_stb,
   input logic [3:0]        cfg_enable,
   input logic [REG_W-1:0]  cfg_rtc_base,
   input logic [REG_W-1:0]  cfg_uart1_base,
   input logic [REG_W-1:0]  cfg_uart2_base,
   input logic [REG_W-1:0]  cfg_par_base,
   input logic [REG_W-1:0]  cfg_game_base,
   input logic              game_en,
   input logic              uart1_en,
   input logic              uart2_en,
   input logic              par_en,
   input logic [ADDR_W-1:0] rtc_base,
   input logic [ADDR_W-1:0] uart1_base,
   input logic [ADDR_W-1:0] uart2_base,
   input logic [ADDR_W-1:0] par_base,
   input logic [ADDR_W-1:0] game_base,
   input logic [IRQ_W-1:0]  rtc_irq,
   input logic [IRQ_W-1:0]  uart1_irq,
   input logic [IRQ_W-1:0]  uart2_irq,
   input logic [IRQ_W-1:0]  par_irq
);

   localparam logic [ADDR_SHIFT-1:0] ZS = '0;

   function automatic logic legal(input logic [IRQ_W-1:0] v);
      return v == IRQ_W'(3) || v == IRQ_W'(4) || v == IRQ_W'(5) || v == IRQ_W'(7) || v == NO_IRQ;
   endfunction

   // R10
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode && !apply_stb) |=> !(game_en || uart1_en || uart2_en || par_en));

   // R11
   base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !apply_stb |=> ($stable(rtc_base) && $stable(uart1_base) && $stable(uart2_base)
                      && $stable(par_base) && $stable(game_base)));

   // R11
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !apply_stb |=> ($stable(rtc_irq) && $stable(uart1_irq) && $stable(uart2_irq) && $stable(par_irq)));

   // R2
   base_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
      apply_stb |=> (rtc_base == {$past(cfg_rtc_base), ZS}) && (uart1_base == {$past(cfg_uart1_base), ZS})
                    && (uart2_base == {$past(cfg_uart2_base), ZS}) && (par_base == {$past(cfg_par_base), ZS})
                    && (game_base == {$past(cfg_game_base), ZS}));

   // R3
   enable_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      apply_stb |=> ({par_en, uart2_en, uart1_en, game_en} == $past(cfg_enable)));

   // R8
   irq_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      legal(rtc_irq) && legal(uart1_irq) && legal(uart2_irq) && legal(par_irq));

   // R8
   irq_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((rtc_irq == NO_IRQ) || (rtc_irq != uart1_irq && rtc_irq != uart2_irq && rtc_irq != par_irq))
      && ((uart1_irq == NO_IRQ) || (uart1_irq != uart2_irq && uart1_irq != par_irq))
      && ((uart2_irq == NO_IRQ) || (uart2_irq != par_irq)));

endmodule

bind pirq_router pirq_router_chk #(
   .REG_W(REG_W), .ADDR_SHIFT(ADDR_SHIFT), .IRQ_W(IRQ_W), .NO_IRQ(NO_IRQ)
) i_chk (
   .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .apply_stb(apply_stb),
   .cfg_enable(cfg_enable), .cfg_rtc_base(cfg_rtc_base), .cfg_uart1_base(cfg_uart1_base),
   .cfg_uart2_base(cfg_uart2_base), .cfg_par_base(cfg_par_base), .cfg_game_base(cfg_game_base),
   .game_en(game_en), .uart1_en(uart1_en), .uart2_en(uart2_en), .par_en(par_en),
   .rtc_base(rtc_base), .uart1_base(uart1_base), .uart2_base(uart2_base),
   .par_base(par_base), .game_base(game_base),
   .rtc_irq(rtc_irq), .uart1_irq(uart1_irq), .uart2_irq(uart2_irq), .par_irq(par_irq)
);

// File: tb/test_pirq_router.sv
module test_pirq_router;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_mode = 1'b0;
   logic apply_stb = 1'b0;
   logic [3:0] cfg_enable = '0;
   logic [7:0] cfg_rtc_base = '0, cfg_uart1_base = '0, cfg_uart2_base = '0;
   logic [7:0] cfg_par_base = '0, cfg_game_base = '0, cfg_irq_sel = '0;
   logic game_en, uart1_en, uart2_en, par_en;
   logic [9:0] rtc_base, rtc_fixed_base, uart1_base, uart2_base, par_base, game_base;
   logic [3:0] rtc_irq, uart1_irq, uart2_irq, par_irq;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pirq_router i_pirq_router (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .apply_stb(apply_stb),
      .cfg_enable(cfg_enable), .cfg_rtc_base(cfg_rtc_base), .cfg_uart1_base(cfg_uart1_base),
      .cfg_uart2_base(cfg_uart2_base), .cfg_par_base(cfg_par_base), .cfg_game_base(cfg_game_base),
      .cfg_irq_sel(cfg_irq_sel),
      .game_en(game_en), .uart1_en(uart1_en), .uart2_en(uart2_en), .par_en(par_en),
      .rtc_base(rtc_base), .rtc_fixed_base(rtc_fixed_base), .uart1_base(uart1_base),
      .uart2_base(uart2_base), .par_base(par_base), .game_base(game_base),
      .rtc_irq(rtc_irq), .uart1_irq(uart1_irq), .uart2_irq(uart2_irq), .par_irq(par_irq)
   );

   // {enable[3:0], selector[7:0], expected irq rtc, uart1, uart2, parallel}
   localparam logic [27:0] VEC [0:18] = '{
      {4'h0, 8'h00, 16'hFFFF},  // R8 nothing assigned
      {4'h1, 8'h40, 16'h3FFF},  // R4
      {4'h2, 8'h80, 16'hF3FF},  // R4
      {4'h4, 8'hC0, 16'hFF3F},  // R4
      {4'h8, 8'h10, 16'h4FFF},  // R5
      {4'h3, 8'h20, 16'hF4FF},  // R5
      {4'h5, 8'h30, 16'hFF4F},  // R5
      {4'h9, 8'h04, 16'h5FFF},  // R6
      {4'h6, 8'h08, 16'hF5FF},  // R6
      {4'hA, 8'h0C, 16'hFFF5},  // R6
      {4'hC, 8'h01, 16'h7FFF},  // R7
      {4'h7, 8'h02, 16'hFF7F},  // R7
      {4'hB, 8'h03, 16'hFFF7},  // R7
      {4'hD, 8'hEC, 16'hF435},  // mixed
      {4'hE, 8'h55, 16'h7FFF},  // R9 rtc 3,4,5 then 7
      {4'hF, 8'hA8, 16'hF5FF},  // R9 uart1 3,4 then 5
      {4'h0, 8'hF2, 16'hFF7F},  // R9 uart2 3,4 then 7
      {4'h1, 8'h8F, 16'hF3F7},  // R9 parallel 5 then 7
      {4'h2, 8'h9B, 16'h45F7}   // R9 mixed override
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic apply_now();
      @(negedge clk);
      apply_stb = 1'b1;
      @(negedge clk);
      apply_stb = 1'b0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 enables", {par_en, uart2_en, uart1_en, game_en}, 4'h0);
      chk("R1 rtc_base", rtc_base, 10'h2C0);
      chk("R1 uart1_base", uart1_base, 10'h3F8);
      chk("R1 uart2_base", uart2_base, 10'h2F8);
      chk("R1 par_base", par_base, 10'h278);
      chk("R1 game_base", game_base, 10'h200);
      chk("R1 irqs", {rtc_irq, uart1_irq, uart2_irq, par_irq}, 16'hF435);
      chk("R12 fixed port", rtc_fixed_base, 10'h070);

      // table walk: enables (R3) and irq steering (R4 R5 R6 R7 R8 R9)
      for (int i = 0; i < 19; i++) begin
         cfg_enable  = VEC[i][27:24];
         cfg_irq_sel = VEC[i][23:16];
         apply_now();
         chk($sformatf("R3 enables vec%0d", i), {par_en, uart2_en, uart1_en, game_en}, VEC[i][27:24]);
         chk($sformatf("irq R4/R5/R6/R7/R8/R9 vec%0d", i),
             {rtc_irq, uart1_irq, uart2_irq, par_irq}, VEC[i][15:0]);
      end

      // R2 base scaling, two patterns
      cfg_rtc_base = 8'hFF; cfg_uart1_base = 8'h00; cfg_uart2_base = 8'hA5;
      cfg_par_base = 8'h5A; cfg_game_base = 8'h1C;
      apply_now();
      chk("R2 rtc", rtc_base, 10'h3FC);
      chk("R2 uart1", uart1_base, 10'h000);
      chk("R2 uart2", uart2_base, 10'h294);
      chk("R2 par", par_base, 10'h168);
      chk("R2 game", game_base, 10'h070);
      cfg_rtc_base = 8'h1C; cfg_uart1_base = 8'hFE; cfg_uart2_base = 8'h01;
      cfg_par_base = 8'h80; cfg_game_base = 8'h7F;
      apply_now();
      chk("R2 pattern2", {rtc_base, uart1_base, uart2_base, par_base, game_base},
          {10'h070, 10'h3F8, 10'h004, 10'h200, 10'h1FC});

      // R11 input changes without apply are ignored
      cfg_rtc_base = 8'h33; cfg_uart1_base = 8'h44; cfg_uart2_base = 8'h55;
      cfg_par_base = 8'h66; cfg_game_base = 8'h77; cfg_irq_sel = 8'hFF;
      repeat (3) @(negedge clk);
      chk("R11 bases held", {rtc_base, uart1_base, uart2_base, par_base, game_base},
          {10'h070, 10'h3F8, 10'h004, 10'h200, 10'h1FC});
      chk("R11 irqs held", {rtc_irq, uart1_irq, uart2_irq, par_irq}, 16'h45F7);

      // R10 configuration mode gating
      cfg_enable = 4'hF; cfg_irq_sel = 8'hEC; cfg_rtc_base = 8'hB0;
      apply_now();
      chk("R10 pre enables", {par_en, uart2_en, uart1_en, game_en}, 4'hF);
      cfg_mode = 1'b1;
      cfg_rtc_base = 8'h12;
      cfg_irq_sel = 8'h55;
      @(negedge clk);
      chk("R10 enables off", {par_en, uart2_en, uart1_en, game_en}, 4'h0);
      chk("R10 rtc base kept", rtc_base, 10'h2C0);
      chk("R10 irqs kept", {rtc_irq, uart1_irq, uart2_irq, par_irq}, 16'hF435);
      cfg_mode = 1'b0;
      repeat (2) @(negedge clk);
      chk("R10 stay off after exit", {par_en, uart2_en, uart1_en, game_en}, 4'h0);
      cfg_rtc_base = 8'hB0; cfg_irq_sel = 8'hEC; cfg_enable = 4'h5;
      apply_now();
      chk("R10 restored by apply", {par_en, uart2_en, uart1_en, game_en}, 4'h5);
      chk("R12 fixed port late", rtc_fixed_base, 10'h070);

      // R1 reset again restores defaults
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 re-reset irqs", {rtc_irq, uart1_irq, uart2_irq, par_irq}, 16'hF435);
      chk("R1 re-reset enables", {par_en, uart2_en, uart1_en, game_en}, 4'h0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule